// File: doc/BRIEF.md
# Averaging Auxiliary ADC Sequencer

This block controls a 10-bit successive-approximation housekeeping converter that sits behind a four-way input selector. Software writes one 11-bit mode word over a simple write port. The word chooses the selector input, the reference, a clock divider ratio, how many conversions to average and whether the result is shifted out serially. Setting the start bit in the same word launches the run.

Each run divides the system clock down to a conversion clock. It then performs one or more conversions of twelve conversion-clock edges each, averages them and latches the 10-bit result. The comparator and capacitor DAC are not modelled here. A bit-decision input tells the sequencer, on each bit edge, whether the trial bit is kept. The start bit clears itself when the run ends, and the block ignores it while a run is in progress.

Top module: `aux_adc_seq`

## Requirements
- R1: Writing a mode word with bit 0 = 1 while idle raises `busy` from the next cycle. Bit 0 of `mode_rd` reads 1 for the whole run and reads 0 once `busy` falls. A write with bit 0 = 0 while idle does not start a run.
- R2: While `busy` is high, bit 0 of a write is ignored. Writing 0 neither aborts the run nor clears the bit, and writing 1 does not restart the run or extend it.
- R3: While `busy` is high, writes still update bits 10:1 of `mode_rd`. The running conversion uses the fields captured at start, and `mux_sel` and `ref_sel` hold their captured values.
- R4: While idle, `mux_sel` equals mode bits 3:2 and `ref_sel` equals mode bit 1.
- R5: The conversion-clock divide ratio is 2^k, where k is mode bits 9:7 (ratio 1 to 128). `conv_tick` is a one-cycle pulse every ratio cycles of `busy`, and the first pulse comes in the ratio-th busy cycle.
- R6: Each conversion uses 12 ticks. Tick 0 samples. Ticks 1 to 10 take the bit decision `cmp_bit` for result bits 9 down to 0 in turn. Tick 11 loads the conversion into the average.
- R7: Mode bits 6:4 give the average count: codes 0 to 5 mean 1, 2, 4, 8, 16 and 32, and codes 6 and 7 mean 32. `busy` stays high for exactly 12 × count × ratio cycles.
- R8: `result` is the sum of the conversions shifted right by log2 of the count, which is the floor of the mean, kept to 10 bits.
- R9: `done` is high for exactly one cycle, the first cycle in which `busy` is low, and `result` already holds the new value in that cycle.
- R10: If mode bit 10 was 1 at start, `sdo_valid` is high for the 10 cycles after `done`, and `sdo` carries the result MSB first. If it was 0, `sdo_valid` stays low.
- R11: After reset, `mode_rd`, `result`, `busy`, `done`, `conv_tick` and `sdo_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode word write strobe |
| wr_data | input | 11 | Mode word to write |
| mode_rd | output | 11 | Current mode word readback |
| cmp_bit | input | 1 | Behavioural comparator decision for the current bit tick |
| conv_tick | output | 1 | Conversion clock edge pulse |
| mux_sel | output | 2 | Input selector control |
| ref_sel | output | 1 | Reference select (0 internal, 1 supply) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Latched averaged result |
| sdo | output | 1 | Serial result data, MSB first |
| sdo_valid | output | 1 | Serial data qualifier |

## Verification
The bench targets the reserved averaging codes. A design that decodes them as anything other than 32 produces a busy time and an average that are both off. It writes to the start bit mid-run in both directions. A sequencer that honours those writes would abort the run or restart it, and the measured busy length would change. It changes the divider and the selector fields mid-run. A design that does not capture them at start would change `mux_sel` or the tick spacing. The bench also runs the largest divider, the largest average count and the serial path, where an off-by-one in the edge count or the shift order shows up as a wrong busy time, a wrong result or a misordered `sdo`.

// File: rtl/aux_adc_pkg.sv
// Package: shared widths, the mode word layout and the averaging decode.
// Assumes an 11-bit mode word whose field positions are fixed by software.
package aux_adc_pkg;
    localparam int RES_W       = 10;
    localparam int AVG_CODE_W  = 3;
    localparam int DIV_CODE_W  = 3;
    localparam int MAX_AVG_LOG = 5;
    localparam int MODE_W      = 1 + DIV_CODE_W + AVG_CODE_W + 2 + 1 + 1;
    localparam int LOG_W       = $clog2(MAX_AVG_LOG + 1);

    // Mode word, MSB first: serial enable, divider, averaging, selector, reference, start
    typedef struct packed {
        logic                  ser_en;
        logic [DIV_CODE_W-1:0] div_code;
        logic [AVG_CODE_W-1:0] avg_code;
        logic [1:0]            mux;
        logic                  ref_sel;
        logic                  start;
    } mode_t;

    // Averaging code to log2(count); codes above the maximum saturate
    function automatic logic [LOG_W-1:0] avg_log2(input logic [AVG_CODE_W-1:0] code);
        if (int'(code) > MAX_AVG_LOG) return LOG_W'(MAX_AVG_LOG);
        return LOG_W'(code);
    endfunction
endpackage

// File: rtl/aux_adc_clkdiv.sv
// Conversion clock divider: emits a one-cycle tick every 2^div_code enabled cycles.
// Assumes div_code is held stable while en is high; clear restarts the count.
module aux_adc_clkdiv #(
    parameter int DIV_CODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  clear,
    input  logic [DIV_CODE_W-1:0] div_code,
    output logic                  tick
);
    localparam int CNT_W = (1 << DIV_CODE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected ratio
    always_comb begin
        limit = CNT_W'((32'd1 << div_code) - 32'd1);
        tick  = en && (cnt == limit);
    end

    // Cycle counter, restarted by clear and wrapped at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R5: every run starts its tick spacing from a zero count
    a_r5_div_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (cnt == '0));
endmodule

// File: rtl/aux_adc_sar_core.sv
// Bit sequencer and averager: 12 ticks per conversion (sample, RES_W bits, load),
// accumulates 2^avg_log conversions and latches the floor of the mean.
// Assumes avg_log is held stable from clear until last_tick.
module aux_adc_sar_core #(
    parameter int RES_W       = 10,
    parameter int MAX_AVG_LOG = 5,
    parameter int LOG_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             cmp_bit,
    input  logic [LOG_W-1:0] avg_log,
    output logic             last_tick,
    output logic [RES_W-1:0] result
);
    localparam int EDGES  = RES_W + 2;
    localparam int EDGE_W = $clog2(EDGES);
    localparam int CONV_W = MAX_AVG_LOG + 1;
    localparam int ACC_W  = RES_W + MAX_AVG_LOG;
    localparam logic [EDGE_W-1:0] LOAD_EDGE = EDGE_W'(EDGES - 1);

    logic [EDGE_W-1:0] edge_cnt;
    logic [CONV_W-1:0] conv_cnt;
    logic [CONV_W-1:0] last_conv;
    logic [RES_W-1:0]  code;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  sum_next;
    logic              load_edge;

    // Decode of the load edge and of the final conversion of the run
    always_comb begin
        last_conv = (CONV_W'(1) << avg_log) - CONV_W'(1);
        load_edge = tick && (edge_cnt == LOAD_EDGE);
        last_tick = load_edge && (conv_cnt == last_conv);
        sum_next  = acc + ACC_W'(code);
    end

    // Edge position within the current conversion
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            edge_cnt <= '0;
        end else if (tick) begin
            edge_cnt <= load_edge ? '0 : edge_cnt + 1'b1;
        end
    end

    // Successive-approximation code: cleared on sample, one decision per bit edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (tick) begin
            if (edge_cnt == '0) begin
                code <= '0;
            end else begin
                for (int i = 0; i < RES_W; i++) begin
                    if (edge_cnt == EDGE_W'(RES_W - i)) code[i] <= cmp_bit;
                end
            end
        end
    end

    // Running sum and conversion count across the averaged run
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc      <= '0;
            conv_cnt <= '0;
        end else if (load_edge) begin
            if (last_tick) begin
                acc      <= '0;
                conv_cnt <= '0;
            end else begin
                acc      <= sum_next;
                conv_cnt <= conv_cnt + 1'b1;
            end
        end
    end

    // Averaged result, latched on the final load edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (last_tick) begin
            result <= RES_W'(sum_next >> avg_log);
        end
    end

    // R7: the conversion count never passes the count selected at start
    a_r7_conv_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        conv_cnt <= last_conv);
    // R6: the edge position stays inside one 12-edge conversion
    a_r6_edge_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= LOAD_EDGE);
endmodule

// File: rtl/aux_adc_serializer.sv
// Result serializer: when enabled at load, shifts RES_W bits out MSB first,
// one per system clock, with a qualifier.
module aux_adc_serializer #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             enable,
    input  logic [RES_W-1:0] data,
    output logic             sdo,
    output logic             sdo_valid
);
    localparam int CNT_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] shreg;
    logic [CNT_W-1:0] remaining;

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            remaining <= '0;
        end else if (load && enable) begin
            shreg     <= data;
            remaining <= CNT_W'(RES_W);
        end else if (remaining != '0) begin
            shreg     <= shreg << 1;
            remaining <= remaining - 1'b1;
        end
    end

    // Output taps
    always_comb begin
        sdo       = shreg[RES_W-1];
        sdo_valid = (remaining != '0);
    end

    // R10: an enabled load presents the MSB in the following cycle
    a_r10_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enable) |=> (sdo_valid && (sdo == $past(data[RES_W-1]))));
endmodule

// File: rtl/aux_adc_seq.sv
// Top: mode register with the self-clearing start bit, the start capture of the
// run fields, and the busy/done control around the divider, the bit sequencer
// and the serializer.
// Assumes one write per cycle; bit 0 of writes is ignored while busy.
module aux_adc_seq
    import aux_adc_pkg::*;
#(
    parameter int RES_BITS = RES_W,
    parameter int AVG_LOG  = MAX_AVG_LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MODE_W-1:0]   wr_data,
    output logic [MODE_W-1:0]   mode_rd,
    input  logic                cmp_bit,
    output logic                conv_tick,
    output logic [1:0]          mux_sel,
    output logic                ref_sel,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                sdo,
    output logic                sdo_valid
);
    mode_t                 mode_q;
    mode_t                 wr_mode;
    logic                  start_ok;
    logic                  last_tick;
    logic                  snap_ser;
    logic [DIV_CODE_W-1:0] snap_div;
    logic [LOG_W-1:0]      snap_log;
    logic [1:0]            snap_mux;
    logic                  snap_ref;

    // Write decode and the start acceptance condition
    always_comb begin
        wr_mode  = mode_t'(wr_data);
        start_ok = wr_en && wr_mode.start && !busy;
    end

    // Mode register: start bit protected while busy, cleared at the end of the run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (wr_en) begin
                mode_q       <= wr_mode;
                mode_q.start <= busy ? mode_q.start : wr_mode.start;
            end
            if (last_tick) mode_q.start <= 1'b0;
        end
    end

    // Run fields captured when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ser <= 1'b0;
            snap_div <= '0;
            snap_log <= '0;
            snap_mux <= '0;
            snap_ref <= 1'b0;
        end else if (start_ok) begin
            snap_ser <= wr_mode.ser_en;
            snap_div <= wr_mode.div_code;
            snap_log <= avg_log2(wr_mode.avg_code);
            snap_mux <= wr_mode.mux;
            snap_ref <= wr_mode.ref_sel;
        end
    end

    // Busy from the accepted start to the final load edge; done one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= last_tick;
            if (start_ok)       busy <= 1'b1;
            else if (last_tick) busy <= 1'b0;
        end
    end

    // Selector and reference: live fields while idle, captured fields during a run
    always_comb begin
        mode_rd = mode_q;
        mux_sel = busy ? snap_mux : mode_q.mux;
        ref_sel = busy ? snap_ref : mode_q.ref_sel;
    end

    aux_adc_clkdiv #(
        .DIV_CODE_W (DIV_CODE_W)
    ) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .clear    (start_ok),
        .div_code (snap_div),
        .tick     (conv_tick)
    );

    aux_adc_sar_core #(
        .RES_W       (RES_BITS),
        .MAX_AVG_LOG (AVG_LOG),
        .LOG_W       (LOG_W)
    ) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .tick      (conv_tick),
        .cmp_bit   (cmp_bit),
        .avg_log   (snap_log),
        .last_tick (last_tick),
        .result    (result)
    );

    aux_adc_serializer #(
        .RES_W (RES_BITS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .enable    (snap_ser),
        .data      (result),
        .sdo       (sdo),
        .sdo_valid (sdo_valid)
    );

    // R1: the start bit reads 1 throughout a run
    a_r1_start_bit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mode_rd[0]);
    // R1: the start bit is clear once the run ends
    a_r1_start_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mode_rd[0]);
    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done follows the end of busy
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R3: selector and reference are frozen during a run
    a_r3_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mux_sel) && $stable(ref_sel)));
endmodule

// File: tb/aux_adc_seq_bench.sv
module aux_adc_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_data = '0;
    logic [10:0] mode_rd;
    logic        cmp_bit = 1'b0;
    logic        conv_tick;
    logic [1:0]  mux_sel;
    logic        ref_sel;
    logic        busy;
    logic        done;
    logic [9:0]  result;
    logic        sdo;
    logic        sdo_valid;

    always #2 clk = ~clk;   // 250 MHz

    aux_adc_seq u_aux_adc_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_rd(mode_rd), .cmp_bit(cmp_bit), .conv_tick(conv_tick),
        .mux_sel(mux_sel), .ref_sel(ref_sel), .busy(busy), .done(done),
        .result(result), .sdo(sdo), .sdo_valid(sdo_valid)
    );

    typedef struct {
        int res;
        int cycles;
        int ticks;
        int ratio;
        bit ser;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   cur_seed = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat(input int seed, input int c);
        return (seed * 131 + c * 347 + 17) % 1024;
    endfunction

    // Comparator model: bit decisions follow the per-conversion pattern (R6)
    int k = 0;
    always @(negedge clk) begin
        if (!busy) begin
            k = 0;
        end else if (conv_tick) begin
            int e;
            int c;
            e = k % 12;
            c = k / 12;
            if (e >= 1 && e <= 10) cmp_bit = pat(cur_seed, c)[10 - e];
            else cmp_bit = 1'b0;
            k++;
        end
    end

    // Monitor: measures each run and compares against the scoreboard
    int busy_len = 0;
    int since_tick = 0;
    int tick_cnt = 0;
    int gap_err = 0;
    int ser_left = 0;
    int ser_val = 0;
    int stray = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_left > 0) begin
                chk(sdo_valid && (sdo == ser_val[ser_left - 1]), "R10 serial bit",
                    {sdo_valid, sdo}, {1'b1, ser_val[ser_left - 1]});
                ser_left--;
            end else if (sdo_valid) begin
                stray++;
            end
            if (busy) begin
                busy_len++;
                since_tick++;
                if (conv_tick) begin
                    tick_cnt++;
                    if (q.size() > 0 && since_tick != q[0].ratio) gap_err++;
                    since_tick = 0;
                end
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(result == e.res, "R8 averaged result", result, e.res);
                    chk(busy_len == e.cycles, "R7 busy length", busy_len, e.cycles);
                    chk(tick_cnt == e.ticks, "R6 tick count", tick_cnt, e.ticks);
                    chk(gap_err == 0, "R5 tick spacing errors", gap_err, 0);
                    chk(mode_rd[0] == 1'b0 && !busy, "R1 start auto-clear", mode_rd[0], 0);
                    chk(stray == 0, "R10 stray serial valid", stray, 0);
                    if (e.ser) begin
                        ser_left = 10;
                        ser_val = e.res;
                    end
                end
                busy_len = 0;
                since_tick = 0;
                tick_cnt = 0;
                gap_err = 0;
            end
        end
    end

    task automatic write_mode(input logic [10:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: pushes the expected outcome, then starts the run
    task automatic start_run(input int avg, input int dv, input bit ser,
                             input int mux, input bit rf, input int seed);
        exp_t e;
        int   lg;
        int   n;
        int   sum;
        lg = (avg > 5) ? 5 : avg;
        n = 1 << lg;
        sum = 0;
        for (int c = 0; c < n; c++) sum += pat(seed, c);
        e.res = sum >> lg;
        e.ratio = 1 << dv;
        e.ticks = 12 * n;
        e.cycles = 12 * n * e.ratio;
        e.ser = ser;
        q.push_back(e);
        cur_seed = seed;
        write_mode({ser, 3'(dv), 3'(avg), 2'(mux), rf, 1'b1});
    endtask

    task automatic wait_idle();
        while (busy || q.size() > 0) @(negedge clk);
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(mode_rd == 0, "R11 mode reset", mode_rd, 0);
        chk({busy, done, conv_tick, sdo_valid} == 0, "R11 flags reset",
            {busy, done, conv_tick, sdo_valid}, 0);
        chk(result == 0, "R11 result reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: idle selector follows the mode word; R1: no start without bit 0
        write_mode({1'b0, 3'd0, 3'd0, 2'd2, 1'b1, 1'b0});
        chk(mux_sel == 2'd2 && ref_sel == 1'b1, "R4 idle selector", {mux_sel, ref_sel}, 5);
        repeat (3) @(negedge clk);
        chk(!busy, "R1 no start with bit0 clear", busy, 0);

        // Single conversion, ratio 1
        start_run(0, 0, 0, 1, 0, 3);
        chk(busy && mode_rd[0], "R1 busy and start bit", {busy, mode_rd[0]}, 3);
        wait_idle();

        // Two averaged, ratio 4, serial out
        start_run(1, 2, 1, 0, 1, 7);
        wait_idle();

        // Eight averaged, ratio 2, with mid-run writes (R2, R3)
        start_run(3, 1, 0, 1, 0, 11);
        repeat (5) @(negedge clk);
        write_mode({1'b1, 3'd7, 3'd0, 2'd3, 1'b1, 1'b0});
        chk(busy && mode_rd[0], "R2 clear write ignored", {busy, mode_rd[0]}, 3);
        chk(mode_rd[3:2] == 2'd3 && mode_rd[9:7] == 3'd7, "R3 fields updated",
            {mode_rd[9:7], mode_rd[3:2]}, 31);
        chk(mux_sel == 2'd1 && ref_sel == 1'b0, "R3 selector frozen", {mux_sel, ref_sel}, 2);
        repeat (7) @(negedge clk);
        write_mode({1'b1, 3'd7, 3'd0, 2'd3, 1'b1, 1'b1});
        chk(busy, "R2 set write no restart", busy, 1);
        wait_idle();
        chk(mux_sel == 2'd3 && ref_sel == 1'b1, "R4 selector after run", {mux_sel, ref_sel}, 7);

        // Thirty-two averaged, ratio 1, serial
        start_run(5, 0, 1, 2, 0, 23);
        wait_idle();
        // Reserved code 7 behaves as 32, ratio 2
        start_run(7, 1, 0, 0, 0, 41);
        wait_idle();
        // Reserved code 6, ratio 1, serial
        start_run(6, 0, 1, 3, 1, 57);
        wait_idle();
        // Largest ratio, single conversion, serial
        start_run(0, 7, 1, 1, 1, 99);
        wait_idle();
        // Sixteen averaged, ratio 1
        start_run(4, 0, 0, 2, 1, 5);
        wait_idle();

        chk(q.size() == 0, "R9 all runs completed", q.size(), 0);
        chk(stray == 0, "R10 no serial output when disabled", stray, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule